// File: doc/BRIEF.md
# PS/2 Host Command Transmitter with Lock-LED Sequencer

This block lets a host controller send command bytes to a PS/2 keyboard and collect the keyboard's answer. It drives the two shared lines only through output enables. A high enable pulls the line low, and a low enable releases it to the external pull-up. To start a frame, the block holds the clock low long enough to stop any device traffic. It then pulls data low and lets the clock go. After that it places one bit on the data line per device clock falling edge, and finally samples the acknowledge bit that the device returns.

A small sequencer sits on top of the transmitter and turns one start pulse into a complete exchange. It handles four operations: echo, resend, reset, and a lock-LED update. The LED update is a two-byte exchange, and the second byte is sent only after the device acknowledges the first. Reply bytes arrive from a separate receive path as a byte with a valid strobe. A reply that asks for a retransmission causes the current byte to be sent again, up to a fixed limit. When the exchange ends, the block gives a one-cycle completion pulse with a result code of success, error or timeout.

Top module: `ps2_cmd_host`

## Requirements
- R1: After reset, and at all times while `busy` is low, both `ps2_clk_oe` and `ps2_dat_oe` are 0, so both lines are released.
- R2: A frame starts with `ps2_clk_oe` high for at least INHIBIT_CYC cycles. `ps2_dat_oe` rises while the clock is still held low, and the clock is released only while data is already pulled low.
- R3: After the request, each device clock falling edge moves to the next bit: data bits 0 to 7 (least significant bit first), then an odd parity bit, then a released stop bit. A device that samples on its clock rising edge reads the byte, correct parity and stop = 1.
- R4: At the 11th device clock falling edge the block samples the data line. If the device has not pulled it low (no acknowledge), the exchange ends with result 1 (error).
- R5: Operation code 0 (echo) sends 0xEE. It succeeds (result 0) when the reply byte is 0xEE.
- R6: Operation code 3 (LED update) sends 0xED and waits for 0xFA. It then sends {5'b0, led_mask} and succeeds on a second 0xFA. led_mask bit 0 is Scroll Lock, bit 1 is Num Lock and bit 2 is Caps Lock.
- R7: Operation code 1 (resend) sends 0xFE and succeeds on any reply byte. Operation code 2 (reset) sends 0xFF and succeeds on 0xFA.
- R8: For operation codes 0, 2 and 3, a reply of 0xFE sends the same byte again, at most MAX_RETRY times per byte. A further 0xFE ends the exchange with result 1.
- R9: For operation codes 0, 2 and 3, any reply other than 0xFE or the expected byte ends the exchange with result 1.
- R10: If TIMEOUT_CYC cycles pass with neither a device clock falling edge during a frame nor a reply while waiting, the exchange ends with result 2 and both lines are released.
- R11: `done` is a single-cycle pulse in the cycle that `busy` falls. `result` is 0 for success, 1 for error and 2 for timeout. `reply_byte` holds the last reply byte accepted.
- R12: `cmd_start` while `busy` is high is ignored. `rx_valid` is ignored while a frame is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start pulse for one exchange, sampled while idle |
| cmd_op | input | 2 | Operation: 0 echo, 1 resend, 2 reset, 3 LED update |
| led_mask | input | 3 | LED bits for operation 3 (bit0 scroll, bit1 num, bit2 caps) |
| busy | output | 1 | High from accepted start until completion |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 success, 1 error, 2 timeout; valid with done |
| reply_byte | output | 8 | Last reply byte accepted |
| rx_valid | input | 1 | Strobe from the receive path: a reply byte is present |
| rx_byte | input | 8 | Reply byte from the receive path |
| ps2_clk_i | input | 1 | Level on the shared clock line |
| ps2_dat_i | input | 1 | Level on the shared data line |
| ps2_clk_oe | output | 1 | 1 pulls the clock line low |
| ps2_dat_oe | output | 1 | 1 pulls the data line low |

## Verification
The bench drives a behavioural keyboard that clocks each frame, checks the request, parity and stop bit, and answers in one of seven ways. It can answer correctly, stay silent after the frame, never clock at all, always ask for a resend, ask for a resend once, give a wrong byte, or withhold the acknowledge bit. Directed runs try each answer style against the operation it best exposes. A correct answer separates the four command bytes and the two-byte LED chain. A one-time resend request tests whether the same byte is repeated before the chain moves on, and a persistent one tests whether the retry limit holds. A silent device and a dead device tell apart the wait-for-reply timeout and the mid-frame timeout. A missing acknowledge tests whether bit 11 is actually sampled. Random runs then mix operations, answer styles and LED masks. A disturbance run injects a second start pulse and a stray reply byte during a frame, and must leave the outcome unchanged.

// File: rtl/ps2h_pkg.sv
package ps2h_pkg;

   localparam int BYTE_W     = 8;
   localparam int FRAME_BITS = 11;

   typedef enum logic [1:0] {
      OP_ECHO   = 2'd0,
      OP_RESEND = 2'd1,
      OP_RESET  = 2'd2,
      OP_LEDS   = 2'd3
   } ps2h_op_e;

   typedef enum logic [1:0] {
      RES_OK      = 2'd0,
      RES_ERR     = 2'd1,
      RES_TIMEOUT = 2'd2
   } ps2h_res_e;

   localparam logic [BYTE_W-1:0] BYTE_ECHO   = 8'hEE;
   localparam logic [BYTE_W-1:0] BYTE_RESEND = 8'hFE;
   localparam logic [BYTE_W-1:0] BYTE_RESET  = 8'hFF;
   localparam logic [BYTE_W-1:0] BYTE_LEDS   = 8'hED;
   localparam logic [BYTE_W-1:0] BYTE_ACK    = 8'hFA;

   function automatic logic odd_par(input logic [BYTE_W-1:0] b);
      return ~(^b);
   endfunction

endpackage

// File: rtl/ps2h_sync.sv
module ps2h_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   generate
      if (STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b1;
            else        q <= line_i;
         end
         assign line_o = q;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= {sh_q[STAGES-2:0], line_i};
         end
         assign line_o = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/ps2h_timer.sv
module ps2h_timer #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic expired
);
   localparam int W = $clog2(LIMIT + 1);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (clr)                cnt_q <= '0;
      else if (cnt_q != W'(LIMIT)) cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q == W'(LIMIT));
endmodule

// File: rtl/ps2h_tx.sv
module ps2h_tx
   import ps2h_pkg::*;
#(
   parameter int INHIBIT_CYC = 12500
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              abort,
   input  logic              clk_fall,
   input  logic              dat_lvl,
   output logic              clk_oe,
   output logic              dat_oe,
   output logic              done,
   output logic              acked
);
   localparam int CW = $clog2(INHIBIT_CYC + 1);
   localparam int EW = $clog2(FRAME_BITS);

   typedef enum logic [1:0] {TX_IDLE, TX_HOLD, TX_REQ, TX_SHIFT} tx_state_e;

   tx_state_e             st_q;
   logic [CW-1:0]         hold_q;
   logic [FRAME_BITS-1:0] frame_q;
   logic [EW-1:0]         edge_q;
   logic                  done_q;
   logic                  ack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= TX_IDLE;
         hold_q  <= '0;
         frame_q <= '1;
         edge_q  <= '0;
         done_q  <= 1'b0;
         ack_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (abort) begin
            st_q <= TX_IDLE;
         end else begin
            unique case (st_q)
               TX_IDLE: if (start) begin
                  frame_q <= {1'b1, odd_par(byte_i), byte_i, 1'b0};
                  hold_q  <= '0;
                  edge_q  <= '0;
                  st_q    <= TX_HOLD;
               end
               TX_HOLD: begin
                  if (hold_q == CW'(INHIBIT_CYC - 1)) st_q <= TX_REQ;
                  else                               hold_q <= hold_q + 1'b1;
               end
               TX_REQ: st_q <= TX_SHIFT;
               TX_SHIFT: if (clk_fall) begin
                  if (edge_q == EW'(FRAME_BITS - 1)) begin
                     done_q <= 1'b1;
                     ack_q  <= ~dat_lvl;
                     st_q   <= TX_IDLE;
                  end else begin
                     frame_q <= {1'b1, frame_q[FRAME_BITS-1:1]};
                     edge_q  <= edge_q + 1'b1;
                  end
               end
               default: st_q <= TX_IDLE;
            endcase
         end
      end
   end

   assign clk_oe = (st_q == TX_HOLD) || (st_q == TX_REQ);
   assign dat_oe = (st_q == TX_REQ) || ((st_q == TX_SHIFT) && !frame_q[0]);
   assign done   = done_q;
   assign acked  = ack_q;
endmodule

// File: rtl/ps2_cmd_host.sv
module ps2_cmd_host
   import ps2h_pkg::*;
#(
   parameter int INHIBIT_CYC = 12500,
   parameter int TIMEOUT_CYC = 2500000,
   parameter int MAX_RETRY   = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_start,
   input  logic [1:0]  cmd_op,
   input  logic [2:0]  led_mask,
   output logic        busy,
   output logic        done,
   output logic [1:0]  result,
   output logic [7:0]  reply_byte,
   input  logic        rx_valid,
   input  logic [7:0]  rx_byte,
   input  logic        ps2_clk_i,
   input  logic        ps2_dat_i,
   output logic        ps2_clk_oe,
   output logic        ps2_dat_oe
);
   localparam int RW = $clog2(MAX_RETRY + 2);

   generate
      if (INHIBIT_CYC < 2) begin : g_bad_inhibit
         $error("INHIBIT_CYC must be at least 2");
      end
      if (TIMEOUT_CYC <= INHIBIT_CYC + 8) begin : g_bad_timeout
         $error("TIMEOUT_CYC must exceed INHIBIT_CYC by more than 8");
      end
      if (MAX_RETRY < 0 || MAX_RETRY > 15) begin : g_bad_retry
         $error("MAX_RETRY must lie in 0..15");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 1..4");
      end
   endgenerate

   typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} seq_e;

   seq_e              st_q;
   ps2h_op_e          op_q;
   logic [2:0]        mask_q;
   logic              phase_q;
   logic [RW-1:0]     retry_q;
   logic              launch_q;
   logic              done_q;
   logic [1:0]        res_q;
   logic [BYTE_W-1:0] reply_q;

   logic clk_lvl, dat_lvl, clk_prev_q, clk_fall;
   logic tx_done, tx_acked, tx_abort, tmo, tmr_clr;
   logic [BYTE_W-1:0] cur_byte, want_byte;

   ps2h_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .line_i(ps2_clk_i), .line_o(clk_lvl));
   ps2h_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .line_i(ps2_dat_i), .line_o(dat_lvl));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_prev_q <= 1'b1;
      else        clk_prev_q <= clk_lvl;
   end
   assign clk_fall = clk_prev_q & ~clk_lvl;

   always_comb begin
      if (phase_q) begin
         cur_byte = {5'b0, mask_q};
      end else begin
         unique case (op_q)
            OP_ECHO:   cur_byte = BYTE_ECHO;
            OP_RESEND: cur_byte = BYTE_RESEND;
            OP_RESET:  cur_byte = BYTE_RESET;
            default:   cur_byte = BYTE_LEDS;
         endcase
      end
   end
   assign want_byte = (op_q == OP_ECHO) ? BYTE_ECHO : BYTE_ACK;

   assign tmr_clr  = (st_q == S_IDLE) | launch_q | clk_fall | tx_done
                   | (rx_valid & (st_q == S_WAIT));
   assign tx_abort = (st_q == S_SEND) & tmo;

   ps2h_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .expired(tmo));

   ps2h_tx #(.INHIBIT_CYC(INHIBIT_CYC)) u_tx (
      .clk(clk), .rst_n(rst_n), .start(launch_q), .byte_i(cur_byte),
      .abort(tx_abort), .clk_fall(clk_fall), .dat_lvl(dat_lvl),
      .clk_oe(ps2_clk_oe), .dat_oe(ps2_dat_oe),
      .done(tx_done), .acked(tx_acked));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= S_IDLE;
         op_q     <= OP_ECHO;
         mask_q   <= '0;
         phase_q  <= 1'b0;
         retry_q  <= '0;
         launch_q <= 1'b0;
         done_q   <= 1'b0;
         res_q    <= RES_OK;
         reply_q  <= '0;
      end else begin
         done_q   <= 1'b0;
         launch_q <= 1'b0;
         unique case (st_q)
            S_IDLE: if (cmd_start) begin
               op_q     <= ps2h_op_e'(cmd_op);
               mask_q   <= led_mask;
               phase_q  <= 1'b0;
               retry_q  <= '0;
               launch_q <= 1'b1;
               st_q     <= S_SEND;
            end
            S_SEND: begin
               if (tmo) begin
                  st_q <= S_IDLE; done_q <= 1'b1; res_q <= RES_TIMEOUT;
               end else if (tx_done) begin
                  if (tx_acked) begin
                     st_q <= S_WAIT;
                  end else begin
                     st_q <= S_IDLE; done_q <= 1'b1; res_q <= RES_ERR;
                  end
               end
            end
            S_WAIT: begin
               if (tmo) begin
                  st_q <= S_IDLE; done_q <= 1'b1; res_q <= RES_TIMEOUT;
               end else if (rx_valid) begin
                  reply_q <= rx_byte;
                  if (op_q == OP_RESEND) begin
                     st_q <= S_IDLE; done_q <= 1'b1; res_q <= RES_OK;
                  end else if (rx_byte == BYTE_RESEND) begin
                     if (retry_q < RW'(MAX_RETRY)) begin
                        retry_q  <= retry_q + 1'b1;
                        launch_q <= 1'b1;
                        st_q     <= S_SEND;
                     end else begin
                        st_q <= S_IDLE; done_q <= 1'b1; res_q <= RES_ERR;
                     end
                  end else if (rx_byte == want_byte) begin
                     if (op_q == OP_LEDS && !phase_q) begin
                        phase_q  <= 1'b1;
                        retry_q  <= '0;
                        launch_q <= 1'b1;
                        st_q     <= S_SEND;
                     end else begin
                        st_q <= S_IDLE; done_q <= 1'b1; res_q <= RES_OK;
                     end
                  end else begin
                     st_q <= S_IDLE; done_q <= 1'b1; res_q <= RES_ERR;
                  end
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign busy       = (st_q != S_IDLE);
   assign done       = done_q;
   assign result     = res_q;
   assign reply_byte = reply_q;
endmodule

// File: rtl/ps2_cmd_host_chk.sv
module ps2_cmd_host_chk #(
   parameter int INHIBIT_CYC = 12500
) (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       done,
   input logic [1:0] result,
   input logic       ps2_clk_oe,
   input logic       ps2_dat_oe
);
   int unsigned low_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           low_run_q <= 0;
      else if (!ps2_clk_oe)                 low_run_q <= 0;
      else if (low_run_q != 32'hFFFF_FFFF)  low_run_q <= low_run_q + 1;
   end

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ps2_clk_oe && !ps2_dat_oe));                         // R1
   AST_CLK_FREED_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ps2_clk_oe) |-> ps2_dat_oe);                               // R2
   AST_INHIBIT_LONG_ENOUGH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ps2_clk_oe) |-> (low_run_q >= INHIBIT_CYC));               // R2
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                 // R11
   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);                                           // R11
   AST_RESULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (result != 2'd3));                                      // R11
endmodule

bind ps2_cmd_host ps2_cmd_host_chk #(.INHIBIT_CYC(INHIBIT_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .result(result),
   .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe));

// File: tb/ps2_cmd_host_test.sv
module ps2_cmd_host_test;
   localparam int INH   = 40;
   localparam int TMO   = 1500;
   localparam int RETRY = 2;
   localparam int HALF  = 15;

   localparam int M_NORMAL = 0, M_SILENT = 1, M_DEAD = 2, M_FE_ALL = 3,
                  M_FE_ONCE = 4, M_WRONG = 5, M_NOACK = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic       cmd_start = 1'b0;
   logic [1:0] cmd_op = 2'd0;
   logic [2:0] led_mask = 3'd0;
   logic       busy, done;
   logic [1:0] result;
   logic [7:0] reply_byte;
   logic       dev_rx_v = 1'b0, tb_rx_v = 1'b0;
   logic [7:0] dev_rx_b = 8'h00, tb_rx_b = 8'h00;
   logic       rx_valid;
   logic [7:0] rx_byte;
   logic       ps2_clk_oe, ps2_dat_oe;
   logic       dev_clk_pull = 1'b0, dev_dat_pull = 1'b0;
   logic       bus_clk, bus_dat;

   assign rx_valid = dev_rx_v | tb_rx_v;
   assign rx_byte  = dev_rx_v ? dev_rx_b : tb_rx_b;
   assign bus_clk  = ~(ps2_clk_oe | dev_clk_pull);
   assign bus_dat  = ~(ps2_dat_oe | dev_dat_pull);

   ps2_cmd_host #(.INHIBIT_CYC(INH), .TIMEOUT_CYC(TMO), .MAX_RETRY(RETRY),
                  .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
      .led_mask(led_mask), .busy(busy), .done(done), .result(result),
      .reply_byte(reply_byte), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .ps2_clk_i(bus_clk), .ps2_dat_i(bus_dat),
      .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe));

   int n_chk = 0, n_fail = 0;
   int dev_mode = M_NORMAL;
   logic [7:0] dev_log [64];
   int dev_n = 0, dev_err = 0, cmd_frames = 0;
   logic [7:0] exp_f [8];
   int exp_n, exp_res;
   logic [7:0] exp_reply;
   bit exp_chk_reply;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] cmd_byte(input int op);
      case (op)
         0: return 8'hEE;
         1: return 8'hFE;
         2: return 8'hFF;
         default: return 8'hED;
      endcase
   endfunction

   function automatic logic [7:0] normal_reply(input logic [7:0] b);
      if (b == 8'hEE) return 8'hEE;
      if (b == 8'hFE) return 8'hAB;
      return 8'hFA;
   endfunction

   // Behavioural keyboard: clocks the frame, checks request, parity and stop.
   task automatic device_frame(input int hold);
      logic [10:0] bits;
      logic [7:0]  b;
      logic [7:0]  rep;
      bit          has;
      bits = '0;
      if (hold < INH) dev_err++;
      if (bus_dat !== 1'b0) dev_err++;
      repeat (5) @(negedge clk);
      for (int k = 1; k <= 10; k++) begin
         dev_clk_pull = 1'b1;
         repeat (HALF) @(negedge clk);
         dev_clk_pull = 1'b0;
         bits[k] = bus_dat;
         repeat (HALF) @(negedge clk);
      end
      if (dev_mode != M_NOACK) dev_dat_pull = 1'b1;
      repeat (2) @(negedge clk);
      dev_clk_pull = 1'b1;
      repeat (HALF) @(negedge clk);
      dev_clk_pull = 1'b0;
      repeat (HALF) @(negedge clk);
      dev_dat_pull = 1'b0;
      b = bits[8:1];
      if (bits[9] !== ~(^b)) dev_err++;
      if (bits[10] !== 1'b1) dev_err++;
      dev_log[dev_n % 64] = b;
      dev_n++;
      cmd_frames++;
      has = 1'b1;
      rep = normal_reply(b);
      case (dev_mode)
         M_SILENT, M_NOACK: has = 1'b0;
         M_FE_ALL:  rep = 8'hFE;
         M_FE_ONCE: if (cmd_frames == 1) rep = 8'hFE;
         M_WRONG:   rep = 8'h55;
         default: ;
      endcase
      if (has) begin
         repeat (100) @(negedge clk);
         dev_rx_b = rep;
         dev_rx_v = 1'b1;
         @(negedge clk);
         dev_rx_v = 1'b0;
      end
   endtask

   initial begin
      forever begin
         @(negedge clk);
         if (ps2_clk_oe) begin
            int hold;
            hold = 0;
            while (ps2_clk_oe) begin
               hold++;
               @(negedge clk);
            end
            if (dev_mode != M_DEAD) device_frame(hold);
         end
      end
   end

   task automatic push(input logic [7:0] b);
      exp_f[exp_n] = b;
      exp_n++;
   endtask

   task automatic build_exp(input int op, input int mode, input logic [2:0] m);
      logic [7:0] c;
      c = cmd_byte(op);
      exp_n = 0; exp_res = 0; exp_chk_reply = 1'b1;
      exp_reply = normal_reply(c);
      case (mode)
         M_NORMAL: begin push(c); if (op == 3) push({5'b0, m}); end
         M_SILENT: begin push(c); exp_res = 2; exp_chk_reply = 1'b0; end
         M_DEAD:   begin exp_res = 2; exp_chk_reply = 1'b0; end
         M_FE_ALL: begin
            exp_reply = 8'hFE;
            if (op == 1) push(c);
            else begin
               for (int i = 0; i <= RETRY; i++) push(c);
               exp_res = 1;
            end
         end
         M_FE_ONCE: begin
            push(c);
            if (op == 1) exp_reply = 8'hFE;
            else begin push(c); if (op == 3) push({5'b0, m}); end
         end
         M_WRONG: begin push(c); exp_reply = 8'h55; exp_res = (op == 1) ? 0 : 1; end
         default: begin push(c); exp_res = 1; exp_chk_reply = 1'b0; end
      endcase
   endtask

   function automatic string tag_of(input int op, input int mode);
      case (mode)
         M_SILENT, M_DEAD:    return "R10";
         M_NOACK:             return "R4";
         M_FE_ALL, M_FE_ONCE: return (op == 1) ? "R7" : "R8";
         M_WRONG:             return (op == 1) ? "R7" : "R9";
         default: return (op == 0) ? "R5" : (op == 3) ? "R6" : "R7";
      endcase
   endfunction

   task automatic run_cmd(input int op, input int mode, input logic [2:0] m, input bit disturb);
      int base, w;
      string tg;
      tg = tag_of(op, mode);
      dev_mode = mode;
      cmd_frames = 0;
      base = dev_n;
      build_exp(op, mode, m);
      @(negedge clk);
      cmd_start = 1'b1; cmd_op = op[1:0]; led_mask = m;
      @(negedge clk);
      cmd_start = 1'b0;
      if (disturb) begin
         repeat (10) @(negedge clk);
         cmd_start = 1'b1; cmd_op = 2'd3; led_mask = ~m;
         tb_rx_v = 1'b1; tb_rx_b = 8'h55;
         @(negedge clk);
         cmd_start = 1'b0; tb_rx_v = 1'b0;
         tg = "R12";
      end
      w = 0;
      while (!done && w < 20000) begin
         @(negedge clk);
         w++;
      end
      check(done === 1'b1, {tg, " completion"}, done, 1);
      check(result === exp_res[1:0], {tg, " R11 result"}, result, exp_res);
      check(busy === 1'b0, "R11 busy low with done", busy, 0);
      if (exp_chk_reply)
         check(reply_byte === exp_reply, {tg, " R11 reply_byte"}, reply_byte, exp_reply);
      @(negedge clk);
      check(done === 1'b0, "R11 done single cycle", done, 0);
      check(ps2_clk_oe === 1'b0 && ps2_dat_oe === 1'b0, "R1 lines released",
            {ps2_clk_oe, ps2_dat_oe}, 0);
      repeat (60) @(negedge clk);
      check(dev_n - base == exp_n, {tg, " R3 frame count"}, dev_n - base, exp_n);
      for (int i = 0; i < exp_n && i < dev_n - base; i++)
         check(dev_log[(base + i) % 64] === exp_f[i], {tg, " R3 frame byte"},
               dev_log[(base + i) % 64], exp_f[i]);
      check(dev_err == 0, "R2 R3 device-side protocol", dev_err, 0);
      dev_err = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h0000_5EED));
      repeat (3) @(negedge clk);
      check(ps2_clk_oe === 1'b0 && ps2_dat_oe === 1'b0, "R1 reset lines", {ps2_clk_oe, ps2_dat_oe}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(busy === 1'b0, "R1 reset busy", busy, 0);
      check(done === 1'b0, "R11 reset done", done, 0);
      check(ps2_clk_oe === 1'b0 && ps2_dat_oe === 1'b0, "R1 idle lines", {ps2_clk_oe, ps2_dat_oe}, 0);

      run_cmd(0, M_NORMAL, 3'b000, 1'b0);   // R5
      run_cmd(3, M_NORMAL, 3'b101, 1'b0);   // R6
      run_cmd(3, M_NORMAL, 3'b010, 1'b0);   // R6
      run_cmd(1, M_NORMAL, 3'b000, 1'b0);   // R7
      run_cmd(2, M_NORMAL, 3'b000, 1'b0);   // R7
      run_cmd(0, M_FE_ONCE, 3'b000, 1'b0);  // R8
      run_cmd(3, M_FE_ONCE, 3'b111, 1'b0);  // R8
      run_cmd(3, M_FE_ALL, 3'b011, 1'b0);   // R8
      run_cmd(1, M_FE_ALL, 3'b000, 1'b0);   // R7
      run_cmd(0, M_WRONG, 3'b000, 1'b0);    // R9
      run_cmd(2, M_SILENT, 3'b000, 1'b0);   // R10
      run_cmd(3, M_DEAD, 3'b001, 1'b0);     // R10
      run_cmd(0, M_NOACK, 3'b000, 1'b0);    // R4
      run_cmd(0, M_NORMAL, 3'b000, 1'b1);   // R12
      for (int n = 0; n < 30; n++)
         run_cmd(int'($urandom % 4), int'($urandom % 7), 3'($urandom), 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule